// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into one interrupt signal for a processor. Every request line is sampled once per clock into a pending vector. That vector always shows the level the line had one cycle earlier. Software cannot set, clear or latch a pending bit. A software-written enable mask picks which pending sources may reach the processor. The interrupt output is high whenever at least one enabled source is pending.

Software reaches the block through a plain 32-bit register port. The port has a byte address, a write strobe with write data, and a read strobe whose data comes back one cycle later. Only whole-word accesses exist. Two offsets accept writes and discard them. Every other unmapped offset reads as zero and ignores writes.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable mask reads 0x00000000, the pending vector reads 0x00000000, read data is zero and the interrupt output is low.
- R2: Pending bit i equals the level of request input i sampled at the previous rising clock edge. When the input goes low, the bit falls on the next edge; nothing stays latched.
- R3: The interrupt output is high exactly when the bitwise AND of the enable mask and the pending vector is nonzero. It changes in the cycle after a request input changes.
- R4: The enable mask is read and written at byte offset 0x04. A 1 in bit i enables source i. A write takes effect at the clock edge of the write.
- R5: Byte offset 0x0C returns the pending vector when read. A write to 0x0C changes neither the mask nor the pending vector.
- R6: Writes to byte offsets 0x00 and 0x14 are accepted and change no state: the mask and the interrupt output stay as they were.
- R7: Reads from any offset other than 0x04 and 0x0C return zero. Writes to any offset other than 0x04 leave the mask unchanged.
- R8: Read data appears in the cycle after the read strobe is sampled. In any cycle that follows a cycle with no read strobe, read data is zero.
- R9: While reset is low, the interrupt output is low, even before the next clock edge.
- R10: A mask write that enables a pending source raises the interrupt output in the cycle after the write. A mask write that disables the last enabled pending source lowers it in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 32 | Level-sensitive interrupt request lines |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
A corrupted mask bit shows up in two places. It appears on the next read of offset 0x04. It also appears on irq_o in the first cycle where that source is pending and no other enabled source is. A pending bit that sticks or lags shows up in one cycle. It is visible on a read of 0x0C, and on irq_o when its mask bit is set. For that reason the tests keep one source at a time enabled and watch the output on both sides of each clock edge. A decode fault that lets a write to a dummy offset reach the mask shows up on the next read of 0x04 and on irq_o.

// File: rtl/lic_pkg.sv
package lic_pkg;

   // byte offsets of the register window; software decodes these
   localparam int unsigned OFS_NOP_LO = 32'h00;
   localparam int unsigned OFS_ENABLE = 32'h04;
   localparam int unsigned OFS_LEVELS = 32'h0C;
   localparam int unsigned OFS_NOP_HI = 32'h14;

   // smallest address width that reaches every offset above
   localparam int unsigned MIN_ADDR_W = 5;

   typedef enum logic [1:0] {
      RSEL_NONE   = 2'd0,
      RSEL_ENABLE = 2'd1,
      RSEL_LEVELS = 2'd2
   } rsel_e;

endpackage

// File: rtl/lic_level_sample.sv
module lic_level_sample #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic [NUM_SRC-1:0] level_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_count
         $error("lic_level_sample: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] level_q;

   // one flop per source; the pending view is the last sampled level
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) level_q[s] <= 1'b0;
         else        level_q[s] <= req_i[s];
      end
   end

   assign level_o = level_q;

   assert_level_tracks_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (level_o == $past(req_i)));

endmodule

// File: rtl/lic_reg_file.sv
module lic_reg_file
   import lic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               rd_i,
   input  logic [NUM_SRC-1:0] level_i,
   output logic [NUM_SRC-1:0] enable_o,
   output logic [DATA_W-1:0]  rdata_o
);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("lic_reg_file: ADDR_W too small for the register window");
      end
      if (NUM_SRC > DATA_W) begin : g_bad_width
         $error("lic_reg_file: NUM_SRC may not exceed DATA_W");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_LEVELS = ADDR_W'(OFS_LEVELS);

   logic [NUM_SRC-1:0] enable_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [DATA_W-1:0]  rdata_d;
   logic               enable_we;
   rsel_e              rsel;

   // Only the enable offset stores anything. The two dummy offsets and
   // every unmapped offset fall through to "no state change".
   assign enable_we = wr_i && (addr_i == A_ENABLE);

   always_comb begin
      if (addr_i == A_ENABLE)      rsel = RSEL_ENABLE;
      else if (addr_i == A_LEVELS) rsel = RSEL_LEVELS;
      else                         rsel = RSEL_NONE;
   end

   always_comb begin
      unique case (rsel)
         RSEL_ENABLE: rdata_d = DATA_W'(enable_q);
         RSEL_LEVELS: rdata_d = DATA_W'(level_i);
         default:     rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         enable_q <= '0;
      else if (enable_we) enable_q <= wdata_i[NUM_SRC-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rdata_d;
      else           rdata_q <= '0;
   end

   assign enable_o = enable_q;
   assign rdata_o  = rdata_q;

   assert_enable_write_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_ENABLE) |=> (enable_o == $past(wdata_i[NUM_SRC-1:0])));

   assert_enable_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && addr_i == A_ENABLE) |=> $stable(enable_o));

   assert_rdata_idle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (rdata_o == '0));

   assert_unmapped_read_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i != A_ENABLE && addr_i != A_LEVELS) |=> (rdata_o == '0));

endmodule

// File: rtl/lic_irq_merge.sv
module lic_irq_merge #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] enable_i,
   input  logic [NUM_SRC-1:0] level_i,
   output logic               irq_o
);

   logic [NUM_SRC-1:0] live;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
      assign live[s] = enable_i[s] & level_i[s];
   end

   // gated by reset so the output is quiet before the first edge in reset
   assign irq_o = rst_n & (|live);

   always_comb begin
      if (!rst_n) assert_quiet_in_reset_R9 : assert (!irq_o);
   end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   input  logic               bus_rd_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o
);

   logic [NUM_SRC-1:0] level;
   logic [NUM_SRC-1:0] enable;

   lic_level_sample #(.NUM_SRC(NUM_SRC)) u_sample (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_i),
      .level_o (level)
   );

   lic_reg_file #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (bus_addr_i),
      .wr_i     (bus_wr_i),
      .wdata_i  (bus_wdata_i),
      .rd_i     (bus_rd_i),
      .level_i  (level),
      .enable_o (enable),
      .rdata_o  (bus_rdata_o)
   );

   lic_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
      .rst_n    (rst_n),
      .enable_i (enable),
      .level_i  (level),
      .irq_o    (irq_o)
   );

   // an asserted output must trace back to a request seen last cycle
   assert_irq_has_source_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && irq_o) |-> ((enable & $past(req_i)) != '0));

   // with nothing enabled, no request may reach the processor
   assert_irq_needs_enable_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |-> !irq_o);

endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   lvl_irq_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rd_i    (rd),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req_tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      cyc();
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      addr = a; rd = 1'b1;
      cyc();
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rst_n = 1'b0; req = 32'hFFFF_FFFF;
      #1;
      check("R9 irq low in reset", {31'd0, irq}, 32'd0);
      cyc(); cyc();
      check("R9 irq low during reset", {31'd0, irq}, 32'd0);
      req = '0;
      rst_n = 1'b1;
      cyc();
      check("R1 rdata zero", rdata, 32'd0);
      check("R1 irq low", {31'd0, irq}, 32'd0);
      bus_read(8'h04, v); check("R1 mask reset", v, 32'd0);
      bus_read(8'h0C, v); check("R1 pending reset", v, 32'd0);
   endtask

   task automatic t_pending_follows();
      logic [31:0] v;
      req = 32'hA5A5_0001;
      cyc();
      bus_read(8'h0C, v); check("R2 pending follows", v, 32'hA5A5_0001);
      req = 32'h0000_0100;
      cyc();
      bus_read(8'h0C, v); check("R2 no latch after drop", v, 32'h0000_0100);
      req = '0;
      cyc();
      bus_read(8'h0C, v); check("R2 all low", v, 32'd0);
   endtask

   task automatic t_mask_rw();
      logic [31:0] v;
      bus_write(8'h04, 32'hDEAD_BEEF);
      bus_read(8'h04, v); check("R4 mask readback", v, 32'hDEAD_BEEF);
      bus_write(8'h04, 32'h1234_5678);
      bus_read(8'h04, v); check("R4 mask rewrite", v, 32'h1234_5678);
      bus_write(8'h04, 32'd0);
   endtask

   task automatic t_irq_combine();
      bus_write(8'h04, 32'h0000_0010);
      req = 32'h0000_0020;
      cyc();
      check("R3 disabled source no irq", {31'd0, irq}, 32'd0);
      req = 32'h0000_0030;
      #1;
      check("R3 no change before edge", {31'd0, irq}, 32'd0);
      cyc();
      check("R3 irq after edge", {31'd0, irq}, 32'd1);
      req = 32'h0000_0020;
      #1;
      check("R3 still high before edge", {31'd0, irq}, 32'd1);
      cyc();
      check("R3 irq drops with level", {31'd0, irq}, 32'd0);
      req = 32'h8000_0000;
      bus_write(8'h04, 32'h8000_0000);
      check("R10 mask enables pending", {31'd0, irq}, 32'd1);
      bus_write(8'h04, 32'h7FFF_FFFF);
      check("R10 mask disables last", {31'd0, irq}, 32'd0);
      bus_write(8'h04, 32'd0);
      req = '0;
      cyc();
   endtask

   task automatic t_dummy_writes();
      logic [31:0] v;
      bus_write(8'h04, 32'h0000_0004);
      req = 32'h0000_0004;
      cyc();
      check("R6 baseline irq", {31'd0, irq}, 32'd1);
      bus_write(8'h00, 32'd0);
      check("R6 write 0x00 irq kept", {31'd0, irq}, 32'd1);
      bus_write(8'h14, 32'hFFFF_FFFF);
      bus_read(8'h04, v); check("R6 write 0x14 mask kept", v, 32'h0000_0004);
      bus_write(8'h0C, 32'd0);
      bus_read(8'h0C, v); check("R5 pending ignores write", v, 32'h0000_0004);
      bus_read(8'h04, v); check("R5 write 0x0C mask kept", v, 32'h0000_0004);
      bus_write(8'h04, 32'd0);
      req = '0;
      cyc();
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_write(8'h04, 32'h0F0F_0F0F);
      req = 32'hFFFF_FFFF;
      cyc();
      bus_write(8'h08, 32'd0);
      bus_write(8'h05, 32'd0);
      bus_read(8'h04, v); check("R7 unmapped writes ignored", v, 32'h0F0F_0F0F);
      bus_read(8'h00, v); check("R7 read 0x00 zero", v, 32'd0);
      bus_read(8'h08, v); check("R7 read 0x08 zero", v, 32'd0);
      bus_read(8'h14, v); check("R7 read 0x14 zero", v, 32'd0);
      bus_read(8'hFC, v); check("R7 read 0xFC zero", v, 32'd0);
      bus_write(8'h04, 32'd0);
      req = '0;
      cyc();
   endtask

   task automatic t_read_timing();
      bus_write(8'h04, 32'hCAFE_F00D);
      addr = 8'h04; rd = 1'b1;
      #1;
      check("R8 no data before edge", rdata, 32'd0);
      cyc();
      rd = 1'b0;
      check("R8 data one cycle later", rdata, 32'hCAFE_F00D);
      cyc();
      check("R8 zero after idle cycle", rdata, 32'd0);
      bus_write(8'h04, 32'd0);
   endtask

   task automatic t_reset_midrun();
      logic [31:0] v;
      bus_write(8'h04, 32'h0000_0001);
      req = 32'h0000_0001;
      cyc();
      check("R3 armed before reset", {31'd0, irq}, 32'd1);
      rst_n = 1'b0;
      #1;
      check("R9 irq drops at once", {31'd0, irq}, 32'd0);
      cyc();
      req = '0;
      rst_n = 1'b1;
      bus_read(8'h04, v); check("R1 mask cleared by reset", v, 32'd0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_pending_follows();
      t_mask_rw();
      t_irq_combine();
      t_dummy_writes();
      t_unmapped();
      t_read_timing();
      t_reset_midrun();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (WATCHDOG) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule